// File: doc/BRIEF.md
# Sequential Shift-Add Floating-Point Multiplier

This block multiplies two operands held in an unpacked floating-point form. Each operand has a two-bit class (zero, number, infinity, NaN), a sign, a binary exponent, and a mantissa built from `NWORDS` 32-bit words. For a number, the leading one sits at bit `P = 32*(NWORDS-1) + LEAD` and the lowest `GUARD` bits are zero. The mantissa value is therefore `mant / 2^P`, which lies in [1, 2).

A one-cycle `start_i` pulse samples both operands. If the operand classes make the result trivial, the block returns it at once. Otherwise it forms the product with a right-shifting accumulator. The accumulator consumes one multiplier bit per cycle, least significant bit first. It covers an all-zero 32-bit multiplier word in one cycle, or in no cycle when that word is the lowest one. Bits shifted out of the accumulator are folded into a sticky flag. The result is not rounded. `done_o` pulses for one cycle when the result is ready, and the result outputs then hold until the next result.

Top module: `fmul_seq`

## Requirements
- R1: Class codes are zero=0, number=1, infinity=2, NaN=3. The operand with the larger class code acts as y and the other as x. On equal codes, operand b is y. The result is then chosen in this order: y NaN, y infinity, x zero, both numbers.
- R2: When y is NaN, the result is y's class, exponent and mantissa, with sign = sign(a) XOR sign(b) and sticky 0.
- R3: When y is infinity and x is zero, the result is the default NaN: class 3, sign 0, exponent 0, mantissa all ones. When y is infinity and x is not zero, the result is y with the XOR sign.
- R4: When x is zero and y is zero or a number, the result is class 0 with the XOR sign, exponent 0, mantissa 0 and sticky 0.
- R5: For a special case (R2, R3, R4), `done_o` is high in the cycle after the clock edge that samples `start_i`.
- R6: For two numbers, the result is class 1 with the XOR sign. The exponent is the sum of the two exponents modulo 2^EW. The mantissa is floor(Ma*Mb / 2^P), and sticky is the OR of the discarded low bits of Ma*Mb.
- R7: If bit P+1 of that product is set, the mantissa is shifted right once more, its low bit is ORed into sticky, and the exponent gains 1. A number result always has bit P set and bit P+1 clear.
- R8: For two numbers, `done_o` rises N+1 cycles after the start edge, where N is the step count. An all-zero lowest multiplier word costs 0 steps, and a nonzero lowest word costs 32-GUARD steps. Each other lower word costs 1 step if it is zero and 32 steps if it is not. The top word costs LEAD+1 steps.
- R9: `done_o` is a one-cycle pulse. The result outputs stay unchanged from `done_o` until the next result.
- R10: While an operation is in progress, `start_i` and operand changes are ignored, and the result belongs to the operands sampled at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; operands sampled when idle |
| a_cls_i | input | 2 | Class of operand a |
| a_sign_i | input | 1 | Sign of operand a |
| a_exp_i | input | EW | Exponent of operand a |
| a_mant_i | input | 32*NWORDS | Mantissa of operand a |
| b_cls_i | input | 2 | Class of operand b |
| b_sign_i | input | 1 | Sign of operand b |
| b_exp_i | input | EW | Exponent of operand b |
| b_mant_i | input | 32*NWORDS | Mantissa of operand b (multiplier) |
| done_o | output | 1 | One-cycle result-ready pulse |
| r_cls_o | output | 2 | Result class |
| r_sign_o | output | 1 | Result sign |
| r_exp_o | output | EW | Result exponent |
| r_mant_o | output | 32*NWORDS | Unrounded result mantissa |
| r_sticky_o | output | 1 | OR of all bits dropped below the mantissa |

## Verification
The bench builds the block with NWORDS=3, GUARD=3, LEAD=20 and EW=16, which places the leading one at bit 84. With three words, a zeroed middle word is reached while the accumulator already holds nonzero bits, so the one-cycle 32-bit skip must move real data into sticky. A zeroed lowest word exercises the zero-cost skip. The product range [1, 4) reaches both outcomes of the normalising shift. Random class pairs and a sixteen-bit exponent exercise the special-case priority and exponent wraparound.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NUM  = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } fcls_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } fmul_st_e;

endpackage

// File: rtl/fmul_special.sv
module fmul_special
  import fmul_pkg::*;
#(
  parameter int MW = 96,
  parameter int EW = 16
) (
  input  logic [1:0]    a_cls_i,
  input  logic          a_sign_i,
  input  logic [EW-1:0] a_exp_i,
  input  logic [MW-1:0] a_mant_i,
  input  logic [1:0]    b_cls_i,
  input  logic          b_sign_i,
  input  logic [EW-1:0] b_exp_i,
  input  logic [MW-1:0] b_mant_i,
  output logic          spec_o,
  output logic [1:0]    cls_o,
  output logic          sign_o,
  output logic [EW-1:0] exp_o,
  output logic [MW-1:0] mant_o
);

  logic          a_heavy;
  logic [1:0]    x_cls;
  logic [1:0]    y_cls;
  logic [EW-1:0] y_exp;
  logic [MW-1:0] y_mant;
  logic          sgn_x;

  always_comb begin
    a_heavy = (a_cls_i > b_cls_i);
    x_cls   = a_heavy ? b_cls_i  : a_cls_i;
    y_cls   = a_heavy ? a_cls_i  : b_cls_i;
    y_exp   = a_heavy ? a_exp_i  : b_exp_i;
    y_mant  = a_heavy ? a_mant_i : b_mant_i;
    sgn_x   = a_sign_i ^ b_sign_i;

    spec_o = 1'b1;
    cls_o  = y_cls;
    sign_o = sgn_x;
    exp_o  = y_exp;
    mant_o = y_mant;
    if (y_cls == CLS_NAN) begin
      spec_o = 1'b1;
    end else if (y_cls == CLS_INF) begin
      if (x_cls == CLS_ZERO) begin
        cls_o  = CLS_NAN;
        sign_o = 1'b0;
        exp_o  = '0;
        mant_o = '1;
      end
    end else if (x_cls == CLS_ZERO) begin
      cls_o  = CLS_ZERO;
      exp_o  = '0;
      mant_o = '0;
    end else begin
      spec_o = 1'b0;
    end
  end

endmodule

// File: rtl/fmul_step.sv
module fmul_step #(
  parameter int MW = 96
) (
  input  logic [MW-1:0] acc_i,
  input  logic          stk_i,
  input  logic [MW-1:0] xm_i,
  input  logic          skip_i,
  input  logic          ybit_i,
  output logic [MW-1:0] acc_o,
  output logic          stk_o
);

  logic [MW-1:0] shr1;

  always_comb begin
    shr1 = acc_i >> 1;
    if (skip_i) begin
      acc_o = acc_i >> 32;
      stk_o = stk_i | (|acc_i[31:0]);
    end else begin
      acc_o = ybit_i ? (shr1 + xm_i) : shr1;
      stk_o = stk_i | acc_i[0];
    end
  end

endmodule

// File: rtl/fmul_seq.sv
module fmul_seq
  import fmul_pkg::*;
#(
  parameter int NWORDS = 3,
  parameter int GUARD  = 3,
  parameter int LEAD   = 20,
  parameter int EW     = 16,
  localparam int MW    = NWORDS * 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    a_cls_i,
  input  logic          a_sign_i,
  input  logic [EW-1:0] a_exp_i,
  input  logic [MW-1:0] a_mant_i,
  input  logic [1:0]    b_cls_i,
  input  logic          b_sign_i,
  input  logic [EW-1:0] b_exp_i,
  input  logic [MW-1:0] b_mant_i,
  output logic          done_o,
  output logic [1:0]    r_cls_o,
  output logic          r_sign_o,
  output logic [EW-1:0] r_exp_o,
  output logic [MW-1:0] r_mant_o,
  output logic          r_sticky_o
);

  localparam int P  = 32 * (NWORDS - 1) + LEAD;
  localparam int IW = $clog2(MW + 1);

  fmul_st_e      st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [MW-1:0] acc_q, acc_d;
  logic          stk_q, stk_d;
  logic [MW-1:0] xm_q, xm_d;
  logic [MW-1:0] ym_q, ym_d;
  logic [EW-1:0] exp_q, exp_d;
  logic          sgn_q, sgn_d;
  logic          done_q, done_d;
  logic [1:0]    rc_q, rc_d;
  logic          rs_q, rs_d;
  logic [EW-1:0] re_q, re_d;
  logic [MW-1:0] rm_q, rm_d;
  logic          rk_q, rk_d;

  logic          sp_flag;
  logic [1:0]    sp_cls;
  logic          sp_sign;
  logic [EW-1:0] sp_exp;
  logic [MW-1:0] sp_mant;

  logic [31:0]   ywin;
  logic          skip;
  logic          ybit;
  logic [MW-1:0] acc_nx;
  logic          stk_nx;

  fmul_special #(.MW(MW), .EW(EW)) u_special (
    .a_cls_i (a_cls_i),  .a_sign_i(a_sign_i), .a_exp_i(a_exp_i), .a_mant_i(a_mant_i),
    .b_cls_i (b_cls_i),  .b_sign_i(b_sign_i), .b_exp_i(b_exp_i), .b_mant_i(b_mant_i),
    .spec_o  (sp_flag),  .cls_o   (sp_cls),   .sign_o (sp_sign), .exp_o   (sp_exp),
    .mant_o  (sp_mant)
  );

  always_comb begin
    ywin = ym_q[{idx_q[IW-1:5], 5'd0} +: 32];
    skip = (idx_q[4:0] == 5'd0) && (ywin == 32'd0);
    ybit = ym_q[idx_q];
  end

  fmul_step #(.MW(MW)) u_step (
    .acc_i (acc_q), .stk_i (stk_q), .xm_i (xm_q),
    .skip_i(skip),  .ybit_i(ybit),
    .acc_o (acc_nx), .stk_o(stk_nx)
  );

  // next-state logic
  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    acc_d  = acc_q;
    stk_d  = stk_q;
    xm_d   = xm_q;
    ym_d   = ym_q;
    exp_d  = exp_q;
    sgn_d  = sgn_q;
    done_d = 1'b0;
    rc_d   = rc_q;
    rs_d   = rs_q;
    re_d   = re_q;
    rm_d   = rm_q;
    rk_d   = rk_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if (sp_flag) begin
            rc_d   = sp_cls;
            rs_d   = sp_sign;
            re_d   = sp_exp;
            rm_d   = sp_mant;
            rk_d   = 1'b0;
            done_d = 1'b1;
          end else begin
            xm_d  = a_mant_i;
            ym_d  = b_mant_i;
            acc_d = '0;
            stk_d = 1'b0;
            exp_d = a_exp_i + b_exp_i;
            sgn_d = a_sign_i ^ b_sign_i;
            idx_d = (b_mant_i[31:0] == 32'd0) ? IW'(32) : IW'(GUARD);
            st_d  = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        acc_d = acc_nx;
        stk_d = stk_nx;
        idx_d = skip ? (idx_q + IW'(32)) : (idx_q + IW'(1));
        if (!skip && (idx_q == IW'(P))) st_d = ST_FIN;
      end
      ST_FIN: begin
        rc_d   = CLS_NUM;
        rs_d   = sgn_q;
        if (acc_q[P+1]) begin
          rm_d = acc_q >> 1;
          rk_d = stk_q | acc_q[0];
          re_d = exp_q + EW'(1);
        end else begin
          rm_d = acc_q;
          rk_d = stk_q;
          re_d = exp_q;
        end
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      acc_q  <= '0;
      stk_q  <= 1'b0;
      xm_q   <= '0;
      ym_q   <= '0;
      exp_q  <= '0;
      sgn_q  <= 1'b0;
      done_q <= 1'b0;
      rc_q   <= CLS_ZERO;
      rs_q   <= 1'b0;
      re_q   <= '0;
      rm_q   <= '0;
      rk_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      acc_q  <= acc_d;
      stk_q  <= stk_d;
      xm_q   <= xm_d;
      ym_q   <= ym_d;
      exp_q  <= exp_d;
      sgn_q  <= sgn_d;
      done_q <= done_d;
      rc_q   <= rc_d;
      rs_q   <= rs_d;
      re_q   <= re_d;
      rm_q   <= rm_d;
      rk_q   <= rk_d;
    end
  end

  assign done_o     = done_q;
  assign r_cls_o    = rc_q;
  assign r_sign_o   = rs_q;
  assign r_exp_o    = re_q;
  assign r_mant_o   = rm_q;
  assign r_sticky_o = rk_q;

  AST_SPECIAL_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && start_i && sp_flag) |=> done_o); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> !done_o); // R9

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !start_i) |=> ($stable(r_mant_o) && $stable(r_cls_o) && $stable(r_exp_o))); // R9

  AST_NORMALISED: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && r_cls_o == CLS_NUM) |-> (r_mant_o[P] && !r_mant_o[P+1])); // R7

  AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) |-> (idx_q <= IW'(P))); // R8

  AST_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) |=> !done_o); // R10

endmodule

// File: tb/fmul_seq_tb.sv
module fmul_seq_tb;

  localparam int NW = 3;
  localparam int GD = 3;
  localparam int LD = 20;
  localparam int EW = 16;
  localparam int MW = NW * 32;
  localparam int P  = 32 * (NW - 1) + LD;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [1:0]    a_c, b_c;
  logic          a_s, b_s;
  logic [EW-1:0] a_e, b_e;
  logic [MW-1:0] a_m, b_m;
  logic          done;
  logic [1:0]    r_c;
  logic          r_s;
  logic [EW-1:0] r_e;
  logic [MW-1:0] r_m;
  logic          r_k;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  fmul_seq #(.NWORDS(NW), .GUARD(GD), .LEAD(LD), .EW(EW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .a_cls_i(a_c), .a_sign_i(a_s), .a_exp_i(a_e), .a_mant_i(a_m),
    .b_cls_i(b_c), .b_sign_i(b_s), .b_exp_i(b_e), .b_mant_i(b_m),
    .done_o(done), .r_cls_o(r_c), .r_sign_o(r_s), .r_exp_o(r_e),
    .r_mant_o(r_m), .r_sticky_o(r_k)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [MW-1:0] act, input logic [MW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int exp_latency(input logic [MW-1:0] ym);
    int s = 0;
    for (int w = 0; w < NW - 1; w++) begin
      if (ym[w*32 +: 32] == 32'd0) s += (w == 0) ? 0 : 1;
      else                         s += (w == 0) ? (32 - GD) : 32;
    end
    s += LD + 1;
    return s + 1;
  endfunction

  // reference model derived from the requirements
  task automatic ref_model(
    input  logic [1:0] ac, input logic as_, input logic [EW-1:0] ae, input logic [MW-1:0] am,
    input  logic [1:0] bc, input logic bs,  input logic [EW-1:0] be, input logic [MW-1:0] bm,
    output logic [1:0] ec, output logic es, output logic [EW-1:0] ee,
    output logic [MW-1:0] em, output logic ek, output int lat, output string tag);
    logic [1:0]      xc, yc;
    logic [EW-1:0]   ye;
    logic [MW-1:0]   ymn;
    logic [2*MW-1:0] prod, q, mask;
    if (ac > bc) begin xc = bc; yc = ac; ye = ae; ymn = am; end
    else         begin xc = ac; yc = bc; ye = be; ymn = bm; end
    es = as_ ^ bs; ek = 1'b0; lat = 0;
    if (yc == 2'd3) begin
      ec = yc; ee = ye; em = ymn; tag = "R2";
    end else if (yc == 2'd2) begin
      tag = "R3";
      if (xc == 2'd0) begin ec = 2'd3; es = 1'b0; ee = '0; em = '1; end
      else begin ec = yc; ee = ye; em = ymn; end
    end else if (xc == 2'd0) begin
      ec = 2'd0; ee = '0; em = '0; tag = "R4";
    end else begin
      prod = {{MW{1'b0}}, am} * {{MW{1'b0}}, bm};
      mask = {(2*MW){1'b1}} >> (2*MW - P);
      q    = prod >> P;
      ek   = |(prod & mask);
      ee   = ae + be;
      tag  = "R6";
      if (q[P+1]) begin
        ek = ek | q[0];
        q  = q >> 1;
        ee = ee + EW'(1);
        tag = "R7";
      end
      ec  = 2'd1;
      em  = q[MW-1:0];
      lat = exp_latency(bm);
    end
  endtask

  function automatic logic [MW-1:0] rnd_mant(input int zmode);
    logic [MW-1:0] m;
    m = {$urandom, $urandom, $urandom};
    m = m & ~((MW'(1) << GD) - MW'(1));
    m = m & ((MW'(1) << (P + 1)) - MW'(1));
    m[P] = 1'b1;
    if (zmode == 1 || zmode == 3) m[31:0]  = '0;
    if (zmode == 2 || zmode == 3) m[63:32] = '0;
    return m;
  endfunction

  // inject: pulse a second start with other operands during the operation
  task automatic do_op(
    input logic [1:0] ac, input logic as_, input logic [EW-1:0] ae, input logic [MW-1:0] am,
    input logic [1:0] bc, input logic bs,  input logic [EW-1:0] be, input logic [MW-1:0] bm,
    input bit inject, input string xtag);
    logic [1:0] ec; logic es; logic [EW-1:0] ee; logic [MW-1:0] em; logic ek;
    int lat; int n; string tag; string ltag;
    ref_model(ac, as_, ae, am, bc, bs, be, bm, ec, es, ee, em, ek, lat, tag);
    if (xtag != "") tag = xtag;
    @(negedge clk);
    a_c = ac; a_s = as_; a_e = ae; a_m = am;
    b_c = bc; b_s = bs; b_e = be; b_m = bm;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 5000) begin
      if (inject && n == 3) begin
        a_c = 2'd1; a_m = rnd_mant(0); a_e = a_e + 16'd7; a_s = ~a_s;
        b_c = 2'd1; b_m = rnd_mant(0); start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    ltag = (ec == 2'd1 && lat != 0) ? "R8" : "R5";
    if (ac == 2'd1 && bc == 2'd1) ltag = "R8"; else ltag = "R5";
    check(n == lat, ltag, "latency", MW'(n), MW'(lat));
    check(r_c == ec, tag, "class", MW'(r_c), MW'(ec));
    check(r_s == es, tag, "sign", MW'(r_s), MW'(es));
    check(r_e == ee, tag, "exponent", MW'(r_e), MW'(ee));
    check(r_m == em, tag, "mantissa", r_m, em);
    check(r_k == ek, tag, "sticky", MW'(r_k), MW'(ek));
    @(negedge clk);
    // R9: pulse falls, outputs hold
    check(done == 1'b0, "R9", "done pulse width", MW'(done), '0);
    check(r_m == em && r_e == ee && r_c == ec, "R9", "result hold", r_m, em);
    if (inject) check(r_m == em, "R10", "start ignored while busy", r_m, em);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [MW-1:0] one, two_m;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0;
    a_c = '0; a_s = 1'b0; a_e = '0; a_m = '0;
    b_c = '0; b_s = 1'b0; b_e = '0; b_m = '0;
    repeat (3) @(negedge clk);
    check(done == 1'b0 && r_c == 2'd0, "R9", "reset done/class", MW'({done, r_c}), '0);
    check(r_m == '0 && r_k == 1'b0, "R9", "reset mantissa", r_m, '0);
    rst_n = 1'b1;
    @(negedge clk);

    one   = MW'(1) << P;
    two_m = (MW'(1) << (P + 1)) - (MW'(1) << GD);
    // R1 ordering and tie cases
    do_op(2'd3, 1'b1, 16'h11, rnd_mant(0), 2'd1, 1'b0, 16'h22, rnd_mant(0), 1'b0, "R1");
    do_op(2'd3, 1'b0, 16'h11, rnd_mant(1), 2'd3, 1'b1, 16'h33, rnd_mant(2), 1'b0, "R1");
    do_op(2'd2, 1'b1, 16'h5,  rnd_mant(0), 2'd0, 1'b1, 16'h6,  rnd_mant(0), 1'b0, "R3");
    do_op(2'd0, 1'b0, 16'h5,  rnd_mant(0), 2'd2, 1'b1, 16'h6,  rnd_mant(0), 1'b0, "R3");
    do_op(2'd1, 1'b1, 16'h5,  rnd_mant(0), 2'd2, 1'b1, 16'h6,  rnd_mant(0), 1'b0, "R3");
    do_op(2'd0, 1'b1, 16'h5,  rnd_mant(0), 2'd1, 1'b0, 16'h6,  rnd_mant(0), 1'b0, "R4");
    do_op(2'd0, 1'b1, 16'h5,  rnd_mant(0), 2'd0, 1'b1, 16'h6,  rnd_mant(0), 1'b0, "R4");
    // numbers: 1*1, max*max (normalise), wraparound exponent, zero words
    do_op(2'd1, 1'b0, 16'h0001, one,   2'd1, 1'b0, 16'h0002, one,   1'b0, "R6");
    do_op(2'd1, 1'b1, 16'hFFFF, two_m, 2'd1, 1'b0, 16'h0001, two_m, 1'b0, "R7");
    do_op(2'd1, 1'b0, 16'h8000, rnd_mant(0), 2'd1, 1'b1, 16'h8000, rnd_mant(3), 1'b0, "R8");
    do_op(2'd1, 1'b0, 16'h0010, rnd_mant(0), 2'd1, 1'b0, 16'h0020, rnd_mant(2), 1'b0, "R8");
    // start ignored while busy
    do_op(2'd1, 1'b0, 16'h0100, rnd_mant(0), 2'd1, 1'b1, 16'h0200, rnd_mant(0), 1'b1, "R10");

    for (int i = 0; i < 250; i++) begin
      logic [1:0] ca, cb;
      if (($urandom % 10) < 6) begin ca = 2'd1; cb = 2'd1; end
      else begin ca = 2'($urandom); cb = 2'($urandom); end
      do_op(ca, 1'($urandom), 16'($urandom), rnd_mant(int'($urandom % 4)),
            cb, 1'($urandom), 16'($urandom), rnd_mant(int'($urandom % 4)), 1'b0, "");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule